// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from ten sources and presents one maskable request line to a small embedded CPU. Five of the sources are internal: three timer channels and the receive and transmit sides of a serial unit. The other five are external pins. The three timers share one priority level, and the two serial sources share another. Each external pin has a level of its own. Inside a shared level, the lower source index wins.

Each source can be masked on its own. A global threshold blocks every source whose priority number is at or above a programmed value. An in-service register records the sources that have been acknowledged, and a new request reaches the CPU only if it outranks every source still in service. Acknowledge is a one-cycle pulse. The controller then returns an 8-bit type code, and software multiplies that code by 4 to form the vector address. A small register port gives software these functions:
- pending and in-service views;
- mask, threshold, priority and trigger-mode configuration;
- specific and non-specific end-of-interrupt;
- a poll-status read that has no side effects;
- a poll read that also acknowledges the source it reports.

Priority numbers run from 0, the most urgent, to 7. Level 0 is kept free for a nonmaskable source that lives outside this block, so no source uses it by default.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the registers hold these values: MASK (addr 0) 0x03FF, all sources masked; PMASK (addr 1) 8; PEND (addr 2) 0; INSV (addr 3) 0; PRIO_LO (addr 7) 0x58D1; PRIO_HI (addr 8) 0x003E; TRIG (addr 9) 0, all pins edge-triggered. int_o is low.
- R2: Source indices are: 0, 1, 2 for timers 0, 1, 2; 3 for serial receive; 4 for serial transmit; 5 for pin 4; 6 to 9 for pins 0 to 3. The type code of a source is 0x40 plus its index. Default group priorities are: timers 1, serial 2, pin 4 3, pin 0 4, pin 1 5, pin 2 6, pin 3 7. A lower number wins, and on a tie the lower index wins.
- R3: A source whose bit is set in MASK[9:0] never wins arbitration and never raises int_o.
- R4: A source takes part only while its priority number is strictly below PMASK[3:0]. PMASK=0 blocks every source.
- R5: TRIG[k]=1 makes pin k level-sensitive, so its pending bit follows the synchronized pin. TRIG[k]=0 latches a rising edge, and the latched request clears only when the source is acknowledged.
- R6: PEND[9:0] shows every received request that has not been serviced, whatever its mask.
- R7: int_o is high only when an eligible pending source has a priority number strictly below that of every in-service source. An equal or lower-priority request waits.
- R8: When ack_i is high and int_o is high, type_o loads the winner's type code in the next cycle, and the winner's INSV bit is set. type_o then holds until the next ack_i.
- R9: When ack_i is high and int_o is low, type_o becomes 0x3F, and no in-service or pending state changes.
- R10: Writing EOI (addr 4) with bit 15 = 0 clears the INSV bit selected by bits [3:0].
- R11: Writing EOI with bit 15 = 1 clears only the highest-priority in-service bit.
- R12: A read of POLLST (addr 5) returns {valid, 7'b0, type} for the highest eligible pending source, ignoring in-service state, and changes no state. A read of POLL (addr 6) returns the same value and acknowledges that source as ack_i would.
- R13: PRIO_LO holds 3-bit fields for timers [2:0], serial [5:3], pin 4 [8:6], pin 0 [11:9] and pin 1 [14:12]. PRIO_HI holds pin 2 [2:0] and pin 3 [5:3]. Rewriting them changes the ranking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_req_i | input | 3 | One-cycle request strobes from timers 0 to 2 |
| ser_req_i | input | 2 | One-cycle request strobes, bit 0 receive, bit 1 transmit |
| ext_irq_i | input | 5 | Asynchronous external request pins 0 to 4, active high |
| int_o | output | 1 | Maskable interrupt request to the CPU |
| ack_i | input | 1 | One-cycle interrupt acknowledge |
| type_o | output | 8 | Type code captured on acknowledge |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rd_i | input | 1 | Register read strobe; has side effects only at POLL |
| reg_rdata_o | output | 16 | Combinational read data |

## Verification
A corrupted in-service bit shows up at int_o in the same cycle as the fault. A stuck bit blocks requests of equal or lower priority. A lost bit lets them nest too early. Either case appears at the next strobe of a competing source, and a read of INSV shows it directly. A wrong arbitration or threshold result gives a wrong code at POLLST without any acknowledge. A bad edge latch shows in PEND three cycles after the pin changes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC   = 10;
  localparam int NPIN   = 5;
  localparam int NGRP   = 7;
  localparam int PRIO_W = 3;
  localparam int IDX_W  = $clog2(NSRC);

  localparam logic [3:0] A_MASK   = 4'd0;
  localparam logic [3:0] A_PMASK  = 4'd1;
  localparam logic [3:0] A_PEND   = 4'd2;
  localparam logic [3:0] A_INSV   = 4'd3;
  localparam logic [3:0] A_EOI    = 4'd4;
  localparam logic [3:0] A_POLLST = 4'd5;
  localparam logic [3:0] A_POLL   = 4'd6;
  localparam logic [3:0] A_PRIOLO = 4'd7;
  localparam logic [3:0] A_PRIOHI = 4'd8;
  localparam logic [3:0] A_TRIG   = 4'd9;

  // group of each source: timers share 0, serial shares 1, pins own 2..6
  function automatic int src_group(input int s);
    if (s < 3) return 0;
    if (s < 5) return 1;
    return s - 3;
  endfunction

  // group g reset priority: g+1 (level 0 reserved)
  function automatic logic [PRIO_W-1:0] grp_default(input int g);
    return PRIO_W'(g + 1);
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic level_i,
  input  logic clr_i,
  output logic req_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      if (sync_q[STAGES-1] && !prev_q) latch_q <= 1'b1;  // set wins over clear
      else if (clr_i)                  latch_q <= 1'b0;
    end
  end

  assign req_o = level_i ? sync_q[STAGES-1] : latch_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_ctrl_pkg::*;
(
  input  logic [NSRC-1:0]              req_i,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
  output logic                         any_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [PRIO_W:0]              prio_o
);
  // scan high to low with <= so the lowest index wins a tie
  always_comb begin
    prio_o = '1;
    idx_o  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i] && ({1'b0, prio_i[i]} <= prio_o)) begin
        prio_o = {1'b0, prio_i[i]};
        idx_o  = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter logic [7:0] TYPE_BASE = 8'h40,
  parameter logic [7:0] SPUR_TYPE = 8'h3F,
  parameter int         SYNC_STG  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  tmr_req_i,
  input  logic [1:0]  ser_req_i,
  input  logic [4:0]  ext_irq_i,
  output logic        int_o,
  input  logic        ack_i,
  output logic [7:0]  type_o,
  input  logic [3:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  input  logic        reg_rd_i,
  output logic [15:0] reg_rdata_o
);
  localparam int NINT = NSRC - NPIN;

  logic [NSRC-1:0]             mask_q, isr_q, pend, cand, take_oh, eoi_clr;
  logic [3:0]                  pmask_q;
  logic [NGRP-1:0][PRIO_W-1:0] gprio_q;
  logic [NPIN-1:0]             lvl_q, ext_req, pin_clr;
  logic [NINT-1:0]             ipend_q, istrobe;
  logic [NSRC-1:0][PRIO_W-1:0] sprio;
  logic                        req_any, isr_any, take, ack_hit, poll_rd;
  logic [IDX_W-1:0]            win_idx, isr_idx;
  logic [PRIO_W:0]             win_prio, isr_prio;
  logic [7:0]                  type_q, win_type;

  assign istrobe = {ser_req_i, tmr_req_i};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign sprio[s] = gprio_q[src_group(s)];
    assign cand[s]  = pend[s] && !mask_q[s] && ({1'b0, sprio[s]} < pmask_q);
  end

  // pin k -> source: pin 4 is index 5, pins 0..3 are 6..9
  assign pin_clr = {take_oh[5], take_oh[9:6]};
  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    irq_pin_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_irq_i[k]),
      .level_i(lvl_q[k]),
      .clr_i  (pin_clr[k]),
      .req_o  (ext_req[k])
    );
  end

  assign pend = {ext_req[3:0], ext_req[4], ipend_q};

  irq_prio_pick u_pick_req (
    .req_i (cand),
    .prio_i(sprio),
    .any_o (req_any),
    .idx_o (win_idx),
    .prio_o(win_prio)
  );

  irq_prio_pick u_pick_isr (
    .req_i (isr_q),
    .prio_i(sprio),
    .any_o (isr_any),
    .idx_o (isr_idx),
    .prio_o(isr_prio)
  );

  assign int_o    = req_any && (win_prio < isr_prio);
  assign win_type = TYPE_BASE + 8'(win_idx);
  assign ack_hit  = ack_i && int_o;
  assign poll_rd  = reg_rd_i && (reg_addr_i == A_POLL) && req_any;
  assign take     = ack_hit || poll_rd;
  assign take_oh  = take ? (NSRC'(1) << win_idx) : '0;

  always_comb begin
    eoi_clr = '0;
    if (reg_wr_i && reg_addr_i == A_EOI) begin
      if (reg_wdata_i[15]) eoi_clr = isr_any ? (NSRC'(1) << isr_idx) : '0;
      else                 eoi_clr = NSRC'(1) << reg_wdata_i[3:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipend_q <= '0;
      isr_q   <= '0;
      type_q  <= SPUR_TYPE;
    end else begin
      ipend_q <= istrobe | (ipend_q & ~take_oh[NINT-1:0]);
      isr_q   <= (isr_q & ~eoi_clr) | take_oh;
      if (ack_i) type_q <= int_o ? win_type : SPUR_TYPE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      pmask_q <= 4'd8;
      lvl_q   <= '0;
      for (int g = 0; g < NGRP; g++) gprio_q[g] <= grp_default(g);
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_MASK:   mask_q  <= reg_wdata_i[NSRC-1:0];
        A_PMASK:  pmask_q <= reg_wdata_i[3:0];
        A_TRIG:   lvl_q   <= reg_wdata_i[NPIN-1:0];
        A_PRIOLO: for (int g = 0; g < 5; g++)
                    gprio_q[g] <= reg_wdata_i[g*PRIO_W +: PRIO_W];
        A_PRIOHI: for (int g = 5; g < NGRP; g++)
                    gprio_q[g] <= reg_wdata_i[(g-5)*PRIO_W +: PRIO_W];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_MASK:   reg_rdata_o[NSRC-1:0] = mask_q;
      A_PMASK:  reg_rdata_o[3:0]      = pmask_q;
      A_PEND:   reg_rdata_o[NSRC-1:0] = pend;
      A_INSV:   reg_rdata_o[NSRC-1:0] = isr_q;
      A_POLLST, A_POLL:
                reg_rdata_o = {req_any, 7'b0, req_any ? win_type : SPUR_TYPE};
      A_PRIOLO: for (int g = 0; g < 5; g++)
                  reg_rdata_o[g*PRIO_W +: PRIO_W] = gprio_q[g];
      A_PRIOHI: for (int g = 5; g < NGRP; g++)
                  reg_rdata_o[(g-5)*PRIO_W +: PRIO_W] = gprio_q[g];
      A_TRIG:   reg_rdata_o[NPIN-1:0] = lvl_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign type_o = type_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter logic [7:0] SPUR_TYPE = 8'h3F
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       int_o,
  input logic [7:0] type_o,
  input logic       reg_wr_i,
  input logic [9:0] isr_i,
  input logic [9:0] pend_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle: assert (isr_i == '0 && !int_o);
  end

  a_r7_int_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> pend_i != '0);

  a_r8_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && int_o && !reg_wr_i |=> $countones(isr_i) == $past($countones(isr_i)) + 1);

  a_r8_type_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && int_o |=> type_o != SPUR_TYPE);

  a_r8_type_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(type_o));

  a_r9_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !int_o |=> type_o == SPUR_TYPE);

  a_r9_isr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !int_o && !reg_wr_i |=> $stable(isr_i));
endmodule

bind irq_ctrl irq_ctrl_chk #(.SPUR_TYPE(SPUR_TYPE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ack_i   (ack_i),
  .int_o   (int_o),
  .type_o  (type_o),
  .reg_wr_i(reg_wr_i),
  .isr_i   (isr_q),
  .pend_i  (pend)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  tmr_req_i = '0;
  logic [1:0]  ser_req_i = '0;
  logic [4:0]  ext_irq_i = '0;
  logic        int_o;
  logic        ack_i = 1'b0;
  logic [7:0]  type_o;
  logic [3:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic        reg_rd_i = 1'b0;
  logic [15:0] reg_rdata_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] rv;

  always #2 clk_i = ~clk_i;

  irq_ctrl u0 (.*);

  // {strobes t0,t1,t2,rx,tx (bit0=t0)}, {pins 0..4}, mask, pmask, valid, type
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {5'b10100, 5'b00000, 10'h000, 4'd8, 1'b1, 8'h42},
    {5'b11000, 5'b00000, 10'h000, 4'd8, 1'b1, 8'h43},
    {5'b00000, 5'b11000, 10'h000, 4'd8, 1'b1, 8'h45},
    {5'b00000, 5'b00101, 10'h000, 4'd8, 1'b1, 8'h46},
    {5'b00011, 5'b00000, 10'h001, 4'd8, 1'b1, 8'h41},
    {5'b00000, 5'b11111, 10'h020, 4'd8, 1'b1, 8'h46},
    {5'b01000, 5'b00010, 10'h000, 4'd2, 1'b0, 8'h3F},
    {5'b01000, 5'b00010, 10'h000, 4'd3, 1'b1, 8'h43},
    {5'b00001, 5'b00000, 10'h000, 4'd0, 1'b0, 8'h3F},
    {5'b00000, 5'b00000, 10'h000, 4'd8, 1'b0, 8'h3F}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tmr_req_i = '0; ser_req_i = '0; ext_irq_i = '0; ack_i = 1'b0;
    reg_wr_i = 1'b0; reg_rd_i = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    cyc(1);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    cyc(1);
    reg_rd_i = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
    cyc(1);
  endtask

  task automatic strobe(input logic [4:0] s);
    tmr_req_i = s[2:0]; ser_req_i = s[4:3];
    cyc(1);
    tmr_req_i = '0; ser_req_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    cyc(1);
    ack_i = 1'b0;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 int_o", {15'b0, int_o}, 16'h0000);
    peek(4'd0, rv); chk("R1 MASK", rv, 16'h03FF);
    peek(4'd1, rv); chk("R1 PMASK", rv, 16'h0008);
    peek(4'd2, rv); chk("R1 PEND", rv, 16'h0000);
    peek(4'd3, rv); chk("R1 INSV", rv, 16'h0000);
    peek(4'd7, rv); chk("R1 PRIO_LO", rv, 16'h58D1);
    peek(4'd8, rv); chk("R1 PRIO_HI", rv, 16'h003E);
    peek(4'd9, rv); chk("R1 TRIG", rv, 16'h0000);

    // R9 spurious acknowledge while everything is masked
    strobe(5'b00001);
    chk("R9 int_o masked", {15'b0, int_o}, 16'h0000);
    ack();
    chk("R9 type", {8'h0, type_o}, 16'h003F);
    peek(4'd3, rv); chk("R9 INSV", rv, 16'h0000);
    peek(4'd2, rv); chk("R6 PEND masked", rv, 16'h0001);

    // R2/R3/R4 vector table, pins in level mode
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(4'd9, 16'h001F);
      wr(4'd0, {6'b0, VEC[v][22:13]});
      wr(4'd1, {12'b0, VEC[v][12:9]});
      ext_irq_i = VEC[v][27:23];
      strobe(VEC[v][32:28]);
      cyc(4);
      chk($sformatf("R2/R3/R4 vec%0d int_o", v), {15'b0, int_o}, {15'b0, VEC[v][8]});
      rd(4'd5, rv);
      chk($sformatf("R2/R3/R4 vec%0d POLLST", v), rv, {VEC[v][8], 7'b0, VEC[v][7:0]});
      ext_irq_i = '0;
    end

    // R7/R8/R10/R11 nesting
    do_reset();
    wr(4'd0, 16'h0000);
    strobe(5'b10000);
    chk("R7 tx raises int_o", {15'b0, int_o}, 16'h0001);
    ack();
    chk("R8 type tx", {8'h0, type_o}, 16'h0044);
    chk("R8 int_o after ack", {15'b0, int_o}, 16'h0000);
    strobe(5'b01000);
    chk("R7 equal prio waits", {15'b0, int_o}, 16'h0000);
    cyc(3);
    chk("R8 type held", {8'h0, type_o}, 16'h0044);
    strobe(5'b00010);
    chk("R7 higher prio nests", {15'b0, int_o}, 16'h0001);
    ack();
    chk("R8 type t1", {8'h0, type_o}, 16'h0041);
    peek(4'd3, rv); chk("R8 INSV nested", rv, 16'h0012);
    wr(4'd4, 16'h8000);
    peek(4'd3, rv); chk("R11 nonspecific EOI", rv, 16'h0010);
    chk("R7 rx still blocked", {15'b0, int_o}, 16'h0000);
    wr(4'd4, 16'h0004);
    peek(4'd3, rv); chk("R10 specific EOI", rv, 16'h0000);
    chk("R7 rx released", {15'b0, int_o}, 16'h0001);

    // R5 edge and level on pin 2 (source 8)
    do_reset();
    wr(4'd0, 16'h0000);
    ext_irq_i = 5'b00100; cyc(4);
    ext_irq_i = 5'b00000; cyc(4);
    peek(4'd2, rv); chk("R5 edge latched", rv, 16'h0100);
    ack();
    chk("R5 edge type", {8'h0, type_o}, 16'h0048);
    peek(4'd2, rv); chk("R5 edge cleared by ack", rv, 16'h0000);
    wr(4'd4, 16'h0008);
    wr(4'd9, 16'h0004);
    ext_irq_i = 5'b00100; cyc(4);
    peek(4'd2, rv); chk("R5 level high", rv, 16'h0100);
    ext_irq_i = 5'b00000; cyc(4);
    peek(4'd2, rv); chk("R5 level follows pin", rv, 16'h0000);

    // R12 poll status vs poll
    do_reset();
    wr(4'd0, 16'h0000);
    strobe(5'b00100);
    rd(4'd5, rv); chk("R12 POLLST", rv, 16'h8042);
    rd(4'd5, rv); chk("R12 POLLST again", rv, 16'h8042);
    peek(4'd3, rv); chk("R12 POLLST no ack", rv, 16'h0000);
    rd(4'd6, rv); chk("R12 POLL", rv, 16'h8042);
    peek(4'd2, rv); chk("R12 POLL clears pend", rv, 16'h0000);
    peek(4'd3, rv); chk("R12 POLL sets INSV", rv, 16'h0004);

    // R13 reprogrammed priority: pin 3 to level 0
    do_reset();
    wr(4'd0, 16'h0000);
    wr(4'd9, 16'h001F);
    wr(4'd8, 16'h0006);
    peek(4'd8, rv); chk("R13 PRIO_HI readback", rv, 16'h0006);
    ext_irq_i = 5'b01000;
    strobe(5'b00001);
    cyc(4);
    rd(4'd5, rv); chk("R13 pin3 outranks timer", rv, 16'h8049);
    ext_irq_i = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule